// File: doc/BRIEF.md
# Reduction Set Completion Tracker

In a streaming reduction, partial sums of many accumulation sets mix together inside a deeply pipelined adder. This block keeps a live-value count for each set ID, so that the surrounding datapath can tell when one value is all that is left of a set. It watches three kinds of event strobes, each of which carries a set ID:
- a new value entering the reduction;
- an adder operation that consumes operands of a set;
- a set reaching its last live value at the adder output.

Each event kind has its own counter bank, indexed by set ID. The first bank only counts up. The other two only count down.

The live count of a set is the sum of its three bank entries. A query port returns that sum, together with a completion flag, one cycle after the request. The result includes every event and clear that arrives in the same cycle as the query. A clear strobe zeroes all three entries of a set so that the ID can be reused. Every strobe is accepted in every cycle. There is no back-pressure on any port, and the event and query paths never stall.

Top module: `set_tracker`

## Requirements
- R1: After reset every set reports a live count of 0. No query result is flagged valid until a query has been issued.
- R2: A value-entry event for set S raises the live count of S by one.
- R3: An adder-operand event for set S lowers the live count of S by one.
- R4: A last-value event for set S lowers the live count of S by one.
- R5: Events of all three kinds are applied in the same cycle, whether they name different sets or the same set; their effects add up.
- R6: `res_vld` is high in exactly the cycle after a cycle with `qry_vld` high, and low otherwise.
- R7: A query sees the effect of all events and clears presented in the same cycle as the query.
- R8: `res_done` is high exactly when `res_vld` is high and the reported live count equals 1.
- R9: A clear of set S sets its live count to 0. The clear takes precedence over events for S in the same cycle, and other sets keep their counts.
- R10: Counts are CNT_W-bit two's-complement values. A set whose decrements outnumber its entries reports a negative count (for example, -1 reads as all ones).
- R11: Events for the same set in consecutive cycles all accumulate, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, zeroes all counts |
| ent_vld | input | 1 | Value-entry event strobe |
| ent_set | input | SET_W | Set ID of the entering value |
| opd_vld | input | 1 | Adder-operand event strobe |
| opd_set | input | SET_W | Set ID of the adder operation |
| last_vld | input | 1 | Last-value event strobe |
| last_set | input | SET_W | Set ID that reached one live value |
| clr_vld | input | 1 | Clear strobe |
| clr_set | input | SET_W | Set ID to retire |
| qry_vld | input | 1 | Query request |
| qry_set | input | SET_W | Set ID being queried |
| res_vld | output | 1 | Query result valid, one cycle after the request |
| res_cnt | output | CNT_W | Signed live count of the queried set |
| res_done | output | 1 | Live count equals one |

## Verification
The bench applies single events, then mixed events that hit one set in the same cycle, then mixed events spread across three different sets. These patterns show whether each bank responds to the right strobe, and whether same-cycle effects are summed rather than overwritten. Runs of entries to one set in back-to-back cycles expose any lost update in the read-modify-write path. Decrements without prior entries expose a sign or width fault. A clear that arrives together with an entry for the same set, followed by a clear that arrives with an entry for a different set, shows both that the clear takes precedence and that it touches only the set it names.

// File: rtl/settrk_pkg.sv
package settrk_pkg;
  typedef enum logic [1:0] {
    BANK_ENTER   = 2'd0,
    BANK_OPERAND = 2'd1,
    BANK_LAST    = 2'd2
  } bank_kind_e;

  localparam int NUM_BANKS = 3;
endpackage

// File: rtl/settrk_bank.sv
module settrk_bank
  import settrk_pkg::*;
#(
  parameter int         SET_W = 4,
  parameter int         CNT_W = 8,
  parameter bank_kind_e KIND  = BANK_ENTER
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_vld,
  input  logic [SET_W-1:0] upd_set,
  input  logic             clr_vld,
  input  logic [SET_W-1:0] clr_set,
  input  logic [SET_W-1:0] rd_set,
  output logic [CNT_W-1:0] rd_val
);
  localparam int         NSETS = 1 << SET_W;
  // The entry bank only counts up; the other two banks only count down.
  localparam logic [CNT_W-1:0] STEP = (KIND == BANK_ENTER) ? CNT_W'(1) : {CNT_W{1'b1}};

  logic [CNT_W-1:0] mem [NSETS];

  // Update port: read-modify-write in one cycle. A clear is written last, so it wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) mem[i] <= '0;
    end else begin
      if (upd_vld) mem[upd_set] <= mem[upd_set] + STEP;
      if (clr_vld) mem[clr_set] <= '0;
    end
  end

  // Read port, forwarding this cycle's update and clear.
  always_comb begin
    rd_val = mem[rd_set];
    if (upd_vld && (upd_set == rd_set)) rd_val = rd_val + STEP;
    if (clr_vld && (clr_set == rd_set)) rd_val = '0;
  end
endmodule

// File: rtl/settrk_query.sv
module settrk_query #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qry_vld,
  input  logic [CNT_W-1:0] part_a,
  input  logic [CNT_W-1:0] part_b,
  input  logic [CNT_W-1:0] part_c,
  output logic             res_vld,
  output logic [CNT_W-1:0] res_cnt,
  output logic             res_done
);
  logic [CNT_W-1:0] total;

  assign total = part_a + part_b + part_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_cnt  <= '0;
      res_done <= 1'b0;
    end else begin
      res_vld  <= qry_vld;
      if (qry_vld) res_cnt <= total;
      res_done <= qry_vld && (total == CNT_W'(1));
    end
  end
endmodule

// File: rtl/set_tracker.sv
module set_tracker
  import settrk_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent_vld,
  input  logic [SET_W-1:0] ent_set,
  input  logic             opd_vld,
  input  logic [SET_W-1:0] opd_set,
  input  logic             last_vld,
  input  logic [SET_W-1:0] last_set,
  input  logic             clr_vld,
  input  logic [SET_W-1:0] clr_set,
  input  logic             qry_vld,
  input  logic [SET_W-1:0] qry_set,
  output logic             res_vld,
  output logic [CNT_W-1:0] res_cnt,
  output logic             res_done
);
  logic             ev_vld [NUM_BANKS];
  logic [SET_W-1:0] ev_set [NUM_BANKS];
  logic [CNT_W-1:0] part   [NUM_BANKS];

  assign ev_vld[0] = ent_vld;
  assign ev_set[0] = ent_set;
  assign ev_vld[1] = opd_vld;
  assign ev_set[1] = opd_set;
  assign ev_vld[2] = last_vld;
  assign ev_set[2] = last_set;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    settrk_bank #(
      .SET_W(SET_W),
      .CNT_W(CNT_W),
      .KIND (bank_kind_e'(g))
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_vld(ev_vld[g]),
      .upd_set(ev_set[g]),
      .clr_vld(clr_vld),
      .clr_set(clr_set),
      .rd_set (qry_set),
      .rd_val (part[g])
    );
  end

  settrk_query #(.CNT_W(CNT_W)) u_query (
    .clk     (clk),
    .rst_n   (rst_n),
    .qry_vld (qry_vld),
    .part_a  (part[0]),
    .part_b  (part[1]),
    .part_c  (part[2]),
    .res_vld (res_vld),
    .res_cnt (res_cnt),
    .res_done(res_done)
  );
endmodule

// File: rtl/set_tracker_chk.sv
module set_tracker_chk #(
  parameter int SET_W = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_vld,
  input logic [SET_W-1:0] clr_set,
  input logic             qry_vld,
  input logic [SET_W-1:0] qry_set,
  input logic             res_vld,
  input logic [CNT_W-1:0] res_cnt,
  input logic             res_done
);
  assert_resp_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    qry_vld |=> res_vld);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_vld |=> !res_vld);

  assert_done_means_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (res_vld && (res_cnt == CNT_W'(1))));

  assert_one_means_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && (res_cnt == CNT_W'(1))) |-> res_done);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_vld && clr_vld && (clr_set == qry_set)) |=> (res_cnt == '0));
endmodule

bind set_tracker set_tracker_chk #(.SET_W(SET_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_vld (clr_vld),
  .clr_set (clr_set),
  .qry_vld (qry_vld),
  .qry_set (qry_set),
  .res_vld (res_vld),
  .res_cnt (res_cnt),
  .res_done(res_done)
);

// File: tb/tb_set_tracker.sv
`timescale 1ns/1ps
module tb_set_tracker;
  localparam int SET_W = 4;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ent_vld = 0, opd_vld = 0, last_vld = 0, clr_vld = 0, qry_vld = 0;
  logic [SET_W-1:0] ent_set = '0, opd_set = '0, last_set = '0, clr_set = '0, qry_set = '0;
  logic res_vld, res_done;
  logic [CNT_W-1:0] res_cnt;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  set_tracker #(.SET_W(SET_W), .CNT_W(CNT_W)) dut (.*);

  typedef struct packed {
    logic ev; logic [3:0] es;
    logic ov; logic [3:0] os;
    logic lv; logic [3:0] ls;
    logic cv; logic [3:0] cs;
    logic [3:0] qs;
    logic [7:0] exp_cnt;
    logic exp_done;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t [0:NV-1] VEC = '{
    '{1'b1,4'd3, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd3, 8'd1,   1'b1, 4'd2},  // R2 R7
    '{1'b1,4'd3, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd3, 8'd2,   1'b0, 4'd2},  // R2
    '{1'b1,4'd3, 1'b1,4'd3, 1'b0,4'd0, 1'b0,4'd0, 4'd3, 8'd2,   1'b0, 4'd5},  // R5 same set
    '{1'b0,4'd0, 1'b1,4'd3, 1'b0,4'd0, 1'b0,4'd0, 4'd3, 8'd1,   1'b1, 4'd3},  // R3
    '{1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd3, 1'b0,4'd0, 4'd3, 8'd0,   1'b0, 4'd4},  // R4
    '{1'b1,4'd5, 1'b1,4'd7, 1'b1,4'd9, 1'b0,4'd0, 4'd5, 8'd1,   1'b1, 4'd5},  // R5 distinct sets
    '{1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd7, 8'hFF,  1'b0, 4'd10}, // R10
    '{1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd9, 8'hFF,  1'b0, 4'd10}, // R10
    '{1'b1,4'd5, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd5, 8'd2,   1'b0, 4'd11}, // R11
    '{1'b1,4'd5, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd5, 8'd3,   1'b0, 4'd11}, // R11
    '{1'b1,4'd5, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd5, 4'd5, 8'd0,   1'b0, 4'd9},  // R9 clear wins
    '{1'b1,4'd6, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd5, 4'd6, 8'd1,   1'b1, 4'd9},  // R9 other set kept
    '{1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd5, 8'd0,   1'b0, 4'd9},  // R9
    '{1'b1,4'd15,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd15, 8'd1,  1'b1, 4'd8},  // R8 top ID
    '{1'b1,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd0, 8'd1,   1'b1, 4'd8},  // R8 ID zero
    '{1'b0,4'd0, 1'b1,4'd0, 1'b0,4'd0, 1'b0,4'd0, 4'd0, 8'd0,   1'b0, 4'd3}   // R3
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ent_vld = 0; opd_vld = 0; last_vld = 0; clr_vld = 0; qry_vld = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_vld after reset", int'(res_vld), 0);
    chk("R6 no query no result", int'(res_vld), 0);

    // R1: every set reads zero after reset
    for (int s = 0; s < (1 << SET_W); s++) begin
      qry_vld = 1; qry_set = SET_W'(s);
      @(negedge clk);
      chk($sformatf("R1 set %0d count", s), int'(res_cnt), 0);
      chk("R6 result valid", int'(res_vld), 1);
    end
    idle();
    @(negedge clk);
    chk("R6 valid drops", int'(res_vld), 0);

    // Vector table: events and a query in one cycle, result checked next cycle
    for (int i = 0; i < NV; i++) begin
      ent_vld = VEC[i].ev;  ent_set = VEC[i].es;
      opd_vld = VEC[i].ov;  opd_set = VEC[i].os;
      last_vld = VEC[i].lv; last_set = VEC[i].ls;
      clr_vld = VEC[i].cv;  clr_set = VEC[i].cs;
      qry_vld = 1;          qry_set = VEC[i].qs;
      @(negedge clk);
      chk($sformatf("R%0d row %0d count", VEC[i].req, i), int'(res_cnt), int'(VEC[i].exp_cnt));
      chk($sformatf("R%0d row %0d done", VEC[i].req, i), int'(res_done), int'(VEC[i].exp_done));
    end
    idle();

    // R11: five back-to-back entries to set 12, then one query
    for (int k = 0; k < 5; k++) begin
      ent_vld = 1; ent_set = 4'd12;
      @(negedge clk);
    end
    idle();
    qry_vld = 1; qry_set = 4'd12;
    @(negedge clk);
    chk("R11 burst count", int'(res_cnt), 5);
    chk("R8 done low at 5", int'(res_done), 0);

    // R9: clear set 12 with no query, then read it back
    idle(); clr_vld = 1; clr_set = 4'd12;
    @(negedge clk);
    chk("R6 no result without query", int'(res_vld), 0);
    idle(); qry_vld = 1; qry_set = 4'd12;
    @(negedge clk);
    chk("R9 cleared set", int'(res_cnt), 0);
    idle();
    @(negedge clk);

    finished = 1;
    summary();
  end
endmodule